// File: doc/BRIEF.md
# Trap Redirect Unit for a Single-Cycle Core

This block sits between the instruction decoder and both the register file and the program counter of a single-cycle 32-bit processor. When the decoder flags an opcode it cannot execute, or an external interrupt request arrives, the unit converts the current instruction into a forced procedure call. The next PC becomes a fixed handler vector, and the return address (the current PC plus 4) is written into register 30. Register 30 is reserved as the exception link register.

If no event is pending, the decoder's control values pass through unchanged. The unit then picks the next PC from sequential, branch and jump sources, and picks the write-back address and data from the usual sources. The unit also holds the PC register.

During an event cycle the faulting instruction is abandoned. It stores nothing to memory, and its write-back is replaced by the link write. A handler that wants to re-run the instruction returns to the link value minus 4.

Top module: `trap_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the PC register to 0x0.
- R2: With neither event pending, the final next-PC select, write-address select, write-data select, register write enable and memory write enable equal the decoder's values. The next-PC select encoding is 0 = PC+4, 1 = branch target, 2 = jump target, and the next PC has its two low bits cleared.
- R3: An illegal-opcode flag with no interrupt gives next-PC select 3 and next PC 0x4.
- R4: An interrupt request gives next-PC select 4 and next PC 0x8.
- R5: When the illegal-opcode flag and the interrupt request occur in the same cycle, the interrupt wins: select 4, next PC 0x8.
- R6: On either event, write-address select is 1, the write-back address is 30, write-data select is 2 and the write-back data is the current PC plus 4.
- R7: On either event, memory write enable is 0 and register write enable is 1, whatever the decoder asked for.
- R8: Write-address select 0 gives the instruction's RC field as the write-back address, and 1 gives 30. Write-data select 0 gives the ALU result, 1 gives the memory read data and 2 gives PC+4.
- R9: At each rising clock edge outside reset, the PC register loads the next PC, and its two low bits stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_pc_sel | input | 3 | Decoder next-PC select |
| dec_wa_sel | input | 1 | Decoder write-address select |
| dec_wd_sel | input | 2 | Decoder write-data select |
| dec_reg_we | input | 1 | Decoder register write enable |
| dec_mem_we | input | 1 | Decoder memory write enable |
| illop | input | 1 | Illegal or unimplemented opcode flag |
| irq | input | 1 | External interrupt request |
| rc_field | input | 5 | Destination register field of the instruction |
| branch_target | input | 32 | Branch target address |
| jump_target | input | 32 | Jump target address |
| alu_result | input | 32 | ALU output |
| mem_rdata | input | 32 | Memory read data |
| pc | output | 32 | Current PC |
| pc_next | output | 32 | Next PC |
| fin_pc_sel | output | 3 | Final next-PC select |
| fin_wa_sel | output | 1 | Final write-address select |
| fin_wd_sel | output | 2 | Final write-data select |
| fin_reg_we | output | 1 | Final register write enable |
| fin_mem_we | output | 1 | Final memory write enable |
| wb_addr | output | 5 | Register file write address |
| wb_data | output | 32 | Register file write data |

## Verification
The assertions check on every cycle that an event yields the correct vector, applies interrupt priority, writes the link to register 30, and suppresses the store. They also check that control values pass through untouched when no event is pending, and that the PC register follows the next PC with aligned low bits. Other behaviour shows only in the bench's scenarios: the actual target values chosen by each normal select, the alignment of odd branch and jump targets, the three write-data sources, and a reset applied in mid-run.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN       = 32;
    localparam int REG_AW     = 5;
    localparam int PCSEL_W    = 3;
    localparam int WDSEL_W    = 2;
    localparam int ALIGN_BITS = 2;
    localparam int INSN_BYTES = 4;

    localparam logic [REG_AW-1:0] LINK_REG     = REG_AW'(30);
    localparam logic [XLEN-1:0]   VEC_BADOP    = XLEN'(32'h4);
    localparam logic [XLEN-1:0]   VEC_EXTINT   = XLEN'(32'h8);
    localparam logic [XLEN-1:0]   RESET_PC     = '0;

    typedef enum logic [PCSEL_W-1:0] {
        NPC_SEQ    = 3'd0,
        NPC_BRANCH = 3'd1,
        NPC_JUMP   = 3'd2,
        NPC_BADOP  = 3'd3,
        NPC_EXTINT = 3'd4
    } npc_sel_e;

    typedef enum logic [WDSEL_W-1:0] {
        WD_ALU  = 2'd0,
        WD_MEM  = 2'd1,
        WD_LINK = 2'd2
    } wd_sel_e;

    typedef struct packed {
        logic [PCSEL_W-1:0] npc_sel;
        logic               wa_sel;
        logic [WDSEL_W-1:0] wd_sel;
        logic               reg_we;
        logic               mem_we;
    } ctrl_t;

    function automatic logic [XLEN-1:0] align_pc(input logic [XLEN-1:0] a);
        return {a[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  ctrl_t dec_ctrl,
    input  logic  illop,
    input  logic  irq,
    output ctrl_t fin_ctrl,
    output logic  event_taken
);

    logic take_int;
    logic take_bad;

    always_comb begin
        take_int    = irq;
        take_bad    = illop && !irq;
        event_taken = take_int || take_bad;

        fin_ctrl = dec_ctrl;
        if (event_taken) begin
            fin_ctrl.npc_sel = take_int ? NPC_EXTINT : NPC_BADOP;
            fin_ctrl.wa_sel  = 1'b1;
            fin_ctrl.wd_sel  = WD_LINK;
            fin_ctrl.reg_we  = 1'b1;
            fin_ctrl.mem_we  = 1'b0;
        end
    end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PCSEL_W-1:0] npc_sel,
    input  logic [XLEN-1:0]    branch_target,
    input  logic [XLEN-1:0]    jump_target,
    output logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    pc_plus4,
    output logic [XLEN-1:0]    pc_next
);

    logic [XLEN-1:0] raw_next;

    assign pc_plus4 = pc + XLEN'(INSN_BYTES);

    always_comb begin
        case (npc_sel)
            NPC_BRANCH: raw_next = branch_target;
            NPC_JUMP:   raw_next = jump_target;
            NPC_BADOP:  raw_next = VEC_BADOP;
            NPC_EXTINT: raw_next = VEC_EXTINT;
            default:    raw_next = pc_plus4;
        endcase
        pc_next = align_pc(raw_next);
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= RESET_PC;
        else     pc <= pc_next;
    end

    // R9: the register follows the next PC and stays aligned
    a_r9_pc_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pc == $past(pc_next)));
    a_r9_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        pc[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/wb_path.sv
module wb_path
    import trap_pkg::*;
(
    input  logic               wa_sel,
    input  logic [WDSEL_W-1:0] wd_sel,
    input  logic [REG_AW-1:0]  rc_field,
    input  logic [XLEN-1:0]    alu_result,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic [XLEN-1:0]    pc_plus4,
    output logic [REG_AW-1:0]  wb_addr,
    output logic [XLEN-1:0]    wb_data
);

    assign wb_addr = wa_sel ? LINK_REG : rc_field;

    always_comb begin
        case (wd_sel)
            WD_MEM:  wb_data = mem_rdata;
            WD_LINK: wb_data = pc_plus4;
            default: wb_data = alu_result;
        endcase
    end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PCSEL_W-1:0] dec_pc_sel,
    input  logic               dec_wa_sel,
    input  logic [WDSEL_W-1:0] dec_wd_sel,
    input  logic               dec_reg_we,
    input  logic               dec_mem_we,
    input  logic               illop,
    input  logic               irq,
    input  logic [REG_AW-1:0]  rc_field,
    input  logic [XLEN-1:0]    branch_target,
    input  logic [XLEN-1:0]    jump_target,
    input  logic [XLEN-1:0]    alu_result,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    pc_next,
    output logic [PCSEL_W-1:0] fin_pc_sel,
    output logic               fin_wa_sel,
    output logic [WDSEL_W-1:0] fin_wd_sel,
    output logic               fin_reg_we,
    output logic               fin_mem_we,
    output logic [REG_AW-1:0]  wb_addr,
    output logic [XLEN-1:0]    wb_data
);

    ctrl_t           dec_ctrl;
    ctrl_t           fin_ctrl;
    logic            event_taken;
    logic [XLEN-1:0] pc_plus4;

    assign dec_ctrl = '{npc_sel: dec_pc_sel, wa_sel: dec_wa_sel, wd_sel: dec_wd_sel,
                        reg_we: dec_reg_we, mem_we: dec_mem_we};

    trap_arbiter u_arb (
        .dec_ctrl    (dec_ctrl),
        .illop       (illop),
        .irq         (irq),
        .fin_ctrl    (fin_ctrl),
        .event_taken (event_taken)
    );

    pc_unit u_pc (
        .clk           (clk),
        .rst           (rst),
        .npc_sel       (fin_ctrl.npc_sel),
        .branch_target (branch_target),
        .jump_target   (jump_target),
        .pc            (pc),
        .pc_plus4      (pc_plus4),
        .pc_next       (pc_next)
    );

    wb_path u_wb (
        .wa_sel     (fin_ctrl.wa_sel),
        .wd_sel     (fin_ctrl.wd_sel),
        .rc_field   (rc_field),
        .alu_result (alu_result),
        .mem_rdata  (mem_rdata),
        .pc_plus4   (pc_plus4),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data)
    );

    assign fin_pc_sel = fin_ctrl.npc_sel;
    assign fin_wa_sel = fin_ctrl.wa_sel;
    assign fin_wd_sel = fin_ctrl.wd_sel;
    assign fin_reg_we = fin_ctrl.reg_we;
    assign fin_mem_we = fin_ctrl.mem_we;

    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        !(illop || irq) |-> (fin_pc_sel == dec_pc_sel && fin_wa_sel == dec_wa_sel &&
                             fin_wd_sel == dec_wd_sel && fin_reg_we == dec_reg_we &&
                             fin_mem_we == dec_mem_we));
    a_r3_badop_vector: assert property (@(posedge clk) disable iff (rst)
        (illop && !irq) |-> (fin_pc_sel == 3'd3 && pc_next == 32'h4));
    a_r4_int_vector: assert property (@(posedge clk) disable iff (rst)
        irq |-> (fin_pc_sel == 3'd4 && pc_next == 32'h8));
    a_r5_int_wins: assert property (@(posedge clk) disable iff (rst)
        (illop && irq) |-> (pc_next == 32'h8));
    a_r6_link_write: assert property (@(posedge clk) disable iff (rst)
        (illop || irq) |-> (wb_addr == 5'd30 && wb_data == pc + 32'd4));
    a_r7_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        (illop || irq) |-> (!fin_mem_we && fin_reg_we));

endmodule

// File: tb/test_trap_ctrl.sv
`timescale 1ns/1ps
module test_trap_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  dec_pc_sel = '0;
    logic        dec_wa_sel = 1'b0;
    logic [1:0]  dec_wd_sel = '0;
    logic        dec_reg_we = 1'b0;
    logic        dec_mem_we = 1'b0;
    logic        illop = 1'b0;
    logic        irq = 1'b0;
    logic [4:0]  rc_field = '0;
    logic [31:0] branch_target = 32'h0000_1236;
    logic [31:0] jump_target   = 32'h0000_2003;
    logic [31:0] alu_result    = 32'hAAAA_0001;
    logic [31:0] mem_rdata     = 32'h5555_0002;
    logic [31:0] pc, pc_next, wb_data;
    logic [2:0]  fin_pc_sel;
    logic        fin_wa_sel, fin_reg_we, fin_mem_we;
    logic [1:0]  fin_wd_sel;
    logic [4:0]  wb_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_ctrl i_trap_ctrl (
        .clk(clk), .rst(rst), .dec_pc_sel(dec_pc_sel), .dec_wa_sel(dec_wa_sel),
        .dec_wd_sel(dec_wd_sel), .dec_reg_we(dec_reg_we), .dec_mem_we(dec_mem_we),
        .illop(illop), .irq(irq), .rc_field(rc_field), .branch_target(branch_target),
        .jump_target(jump_target), .alu_result(alu_result), .mem_rdata(mem_rdata),
        .pc(pc), .pc_next(pc_next), .fin_pc_sel(fin_pc_sel), .fin_wa_sel(fin_wa_sel),
        .fin_wd_sel(fin_wd_sel), .fin_reg_we(fin_reg_we), .fin_mem_we(fin_mem_we),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    typedef struct packed {
        logic [2:0] sel;  logic wa; logic [1:0] wd; logic rwe; logic mwe;
        logic bad; logic intr; logic [4:0] rc;
        logic [2:0] e_sel; logic [4:0] e_addr; logic [1:0] e_wd; logic e_rwe; logic e_mwe;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7,  3'd0, 5'd7,  2'd0, 1'b1, 1'b0},
        '{3'd1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd3,  3'd1, 5'd3,  2'd1, 1'b1, 1'b0},
        '{3'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd9,  3'd2, 5'd30, 2'd2, 1'b1, 1'b0},
        '{3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd12, 3'd0, 5'd12, 2'd0, 1'b0, 1'b1},
        '{3'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd5,  3'd3, 5'd30, 2'd2, 1'b1, 1'b0},
        '{3'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd6,  3'd4, 5'd30, 2'd2, 1'b1, 1'b0},
        '{3'd2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd8,  3'd4, 5'd30, 2'd2, 1'b1, 1'b0},
        '{3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd1,  3'd3, 5'd30, 2'd2, 1'b1, 1'b0},
        '{3'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd31, 3'd0, 5'd31, 2'd0, 1'b1, 1'b0},
        '{3'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0,  3'd4, 5'd30, 2'd2, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_next(input logic [2:0] s, input logic [31:0] cur);
        case (s)
            3'd1:    return branch_target & ~32'h3;
            3'd2:    return jump_target & ~32'h3;
            3'd3:    return 32'h4;
            3'd4:    return 32'h8;
            default: return (cur + 32'd4) & ~32'h3;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input logic [1:0] w, input logic [31:0] cur);
        case (w)
            2'd1:    return mem_rdata;
            2'd2:    return cur + 32'd4;
            default: return alu_result;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] cur, nxt;
        string tsel, tev;
        repeat (2) @(posedge clk);
        #1 chk("R1 reset pc", pc, 32'h0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            dec_pc_sel = VECS[i].sel;  dec_wa_sel = VECS[i].wa;  dec_wd_sel = VECS[i].wd;
            dec_reg_we = VECS[i].rwe;  dec_mem_we = VECS[i].mwe;
            illop = VECS[i].bad;       irq = VECS[i].intr;       rc_field = VECS[i].rc;
            #1;
            cur = pc;
            nxt = exp_next(VECS[i].e_sel, cur);
            tsel = (VECS[i].e_sel == 3'd3) ? "R3" :
                   (VECS[i].e_sel == 3'd4) ? ((VECS[i].bad && VECS[i].intr) ? "R5" : "R4") : "R2";
            tev  = (VECS[i].bad || VECS[i].intr) ? "R6" : "R8";
            chk({tsel, " pc_sel"}, 32'(fin_pc_sel), 32'(VECS[i].e_sel));
            chk({tsel, " pc_next"}, pc_next, nxt);
            chk({tev, " wb_addr"}, 32'(wb_addr), 32'(VECS[i].e_addr));
            chk({tev, " wd_sel"}, 32'(fin_wd_sel), 32'(VECS[i].e_wd));
            chk({tev, " wb_data"}, wb_data, exp_data(VECS[i].e_wd, cur));
            chk((VECS[i].bad || VECS[i].intr) ? "R7 reg_we" : "R2 reg_we",
                32'(fin_reg_we), 32'(VECS[i].e_rwe));
            chk((VECS[i].bad || VECS[i].intr) ? "R7 mem_we" : "R2 mem_we",
                32'(fin_mem_we), 32'(VECS[i].e_mwe));
            @(posedge clk);
            #1 chk("R9 pc load", pc, nxt);
            @(negedge clk);
        end

        // R6: link value from a non-vector PC after a branch
        dec_pc_sel = 3'd1; illop = 1'b0; irq = 1'b0; dec_mem_we = 1'b0;
        @(posedge clk); #1 chk("R9 branch aligned", pc, 32'h0000_1234);
        @(negedge clk) irq = 1'b1;
        #1 chk("R6 link is pc+4", wb_data, 32'h0000_1238);
        chk("R4 vector from branch", pc_next, 32'h8);
        @(negedge clk) irq = 1'b0; dec_pc_sel = 3'd2;
        @(posedge clk); #1 chk("R9 jump aligned", pc, 32'h0000_2000);

        // R1: reset in mid-run
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1 chk("R1 mid-run reset", pc, 32'h0);
        @(negedge clk) rst = 1'b0; dec_pc_sel = 3'd0;
        @(posedge clk); #1 chk("R2 sequential from zero", pc, 32'h4);

        finish_run();
    end

endmodule